// File: doc/BRIEF.md
# Parallel-In Serial-Out Word FIFO

This block buffers 16-bit words that arrive on a parallel write port and releases them one bit at a time on a serial strobe. Writes use a valid/ready handshake. A word moves when `wr_valid` and `wr_ready` are both high on a clock edge. `wr_ready` is the inverted full state, so back-pressure is simply the buffer being full. A source that holds `wr_valid` while `wr_ready` is low stores nothing and keeps its word.

The serial side runs from one system clock. `sclk_en` is a one-cycle strobe that stands for a serial clock edge. Each strobe that finds the buffer non-empty places one bit on `ser_bit`. That bit stays there until the next accepted strobe. The bit order is selected by `msb_first`. A word leaves the buffer on the strobe that emits its sixteenth bit: the read pointer moves on that edge and the occupancy count drops by one.

Four active-low status outputs are derived from the occupancy: empty, full, more-than-half, and a combined "outside the 1/8 to 7/8 band" indication.

Top module: `piso_fifo`

## Requirements
- R1: On a clock edge with `wr_valid` and `wr_ready` both high, `wr_data` is stored at the tail and occupancy rises by one; `wr_ready` equals `full_n`.
- R2: A write strobe presented while `full_n` is low stores nothing, and the sequence read out later does not contain that word.
- R3: Each `sclk_en` strobe with `empty_n` high puts exactly one bit of the head word on `ser_bit`, visible after that clock edge.
- R4: With `msb_first` low, bit 0 of a word is emitted first and bit 15 last; with `msb_first` high, bit 15 is emitted first and bit 0 last.
- R5: The strobe that emits a word's sixteenth bit removes that word, and occupancy and flags reflect the removal after that same edge.
- R6: While `rst_n` is low, the pointers are at zero, `full_n` and `half_n` are high, and `empty_n` and `aeaf_n` are low.
- R7: `half_n` is low exactly when occupancy is greater than DEPTH/2.
- R8: `aeaf_n` is high exactly when occupancy is in the range DEPTH/8 to 7*DEPTH/8 inclusive.
- R9: `empty_n` is low exactly at zero occupancy; strobes arriving then are ignored and `ser_bit` keeps the last bit emitted.
- R10: `full_n` is low exactly when occupancy equals DEPTH.
- R11: An accepted write and a word-completing strobe on the same edge leave the occupancy, and therefore all flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 16 | Parallel write word |
| wr_ready | output | 1 | Buffer can accept a word (not full) |
| sclk_en | input | 1 | Serial shift strobe, one bit per strobe |
| msb_first | input | 1 | Bit order: 0 = LSB first, 1 = MSB first |
| ser_bit | output | 1 | Serial data output, held between strobes |
| empty_n | output | 1 | Low when the buffer holds no word |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when occupancy exceeds DEPTH/2 |
| aeaf_n | output | 1 | Low below DEPTH/8 or above 7*DEPTH/8 |

## Verification
The assertions rely on `msb_first` being held constant for the whole of each word, and on write and strobe inputs being known whenever reset is released. The bench changes `msb_first` only on word boundaries. It drives every input a short delay after the rising edge, so each strobe is a clean single-cycle pulse. The stimulus sweeps a 16-word configuration through every occupancy from empty to full and back. This covers a blocked write at full, strobes at empty, and a coincident write and word completion at the 1/8 boundary.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
    logic aeaf_n;
  } piso_flags_t;
endpackage

// File: rtl/piso_mem.sv
`timescale 1ns/1ps
module piso_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/piso_ptrs.sv
`timescale 1ns/1ps
module piso_ptrs #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/piso_shifter.sv
`timescale 1ns/1ps
module piso_shifter #(
  parameter int W     = 16,
  localparam int BW   = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         have_word,
  input  logic         msb_first,
  input  logic [W-1:0] head,
  output logic         ser_bit,
  output logic         word_done
);
  localparam logic [BW-1:0] TOP = BW'(W - 1);

  logic [BW-1:0] bit_cnt;
  logic [BW-1:0] sel;
  logic          fire;

  assign fire      = strobe && have_word;
  assign sel       = msb_first ? (TOP - bit_cnt) : bit_cnt;
  assign word_done = fire && (bit_cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      ser_bit <= 1'b0;
    end else if (fire) begin
      ser_bit <= head[sel];
      bit_cnt <= (bit_cnt == TOP) ? '0 : bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/piso_flags.sv
`timescale 1ns/1ps
module piso_flags
  import piso_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ,
  output piso_flags_t   flags
);
  localparam logic [CW-1:0] LO_EDGE = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HI_EDGE = CW'((7 * DEPTH) / 8);
  localparam logic [CW-1:0] MID     = CW'(DEPTH / 2);
  localparam logic [CW-1:0] CAP     = CW'(DEPTH);

  always_comb begin
    flags.empty_n = (occ != '0);
    flags.full_n  = (occ != CAP);
    flags.half_n  = (occ <= MID);
    flags.aeaf_n  = (occ >= LO_EDGE) && (occ <= HI_EDGE);
  end
endmodule

// File: rtl/piso_fifo.sv
`timescale 1ns/1ps
module piso_fifo
  import piso_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              sclk_en,
  input  logic              msb_first,
  output logic              ser_bit,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n,
  output logic              aeaf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     occ;
  logic [WORD_W-1:0] head;
  logic              push;
  logic              pop;
  piso_flags_t       flg;

  assign push = wr_valid && flg.full_n;

  piso_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk   (clk),
    .wen   (push),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (head)
  );

  piso_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .occ    (occ)
  );

  piso_shifter #(.W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (sclk_en),
    .have_word (flg.empty_n),
    .msb_first (msb_first),
    .head      (head),
    .ser_bit   (ser_bit),
    .word_done (pop)
  );

  piso_flags #(.DEPTH(DEPTH)) u_flags (
    .occ   (occ),
    .flags (flg)
  );

  assign wr_ready = flg.full_n;
  assign empty_n  = flg.empty_n;
  assign full_n   = flg.full_n;
  assign half_n   = flg.half_n;
  assign aeaf_n   = flg.aeaf_n;
endmodule

// File: rtl/piso_fifo_chk.sv
`timescale 1ns/1ps
module piso_fifo_chk #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          sclk_en,
  input logic          ser_bit,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          aeaf_n,
  input logic [AW-1:0] wr_ptr,
  input logic [CW-1:0] occ
);
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_valid) |=> $stable(wr_ptr));  // R2

  AST_EMPTY_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && sclk_en) |=> $stable(ser_bit));  // R9

  AST_FULL_IMPLIES_BANDS: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!half_n && !aeaf_n && empty_n));  // R10

  AST_EMPTY_IMPLIES_BANDS: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (half_n && !aeaf_n && full_n));  // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));  // R10

  AST_OCC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ == $past(occ) - 1'b1));  // R11

  AST_NO_FILL_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (occ <= $past(occ)));  // R1
endmodule

bind piso_fifo piso_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .sclk_en  (sclk_en),
  .ser_bit  (ser_bit),
  .empty_n  (empty_n),
  .full_n   (full_n),
  .half_n   (half_n),
  .aeaf_n   (aeaf_n),
  .wr_ptr   (wr_ptr),
  .occ      (occ)
);

// File: tb/test_piso_fifo.sv
`timescale 1ns/1ps
module test_piso_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic        sclk_en = 1'b0;
  logic        msb_first = 1'b0;
  logic        ser_bit;
  logic        empty_n, full_n, half_n, aeaf_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [15:0] model [$];
  logic        last_bit;

  always #4 clk = ~clk;

  piso_fifo #(.DEPTH(DEPTH)) i_piso_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .sclk_en(sclk_en), .msb_first(msb_first),
    .ser_bit(ser_bit), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .aeaf_n(aeaf_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] flags_for(input int n);
    logic e, f, h, a;
    e = (n != 0);
    f = (n != DEPTH);
    h = !(n > DEPTH / 2);
    a = (n >= DEPTH / 8) && (n <= (7 * DEPTH) / 8);
    return {f, e, f, h, a};
  endfunction

  task automatic check_flags(input string req);
    check(req, {27'b0, wr_ready, empty_n, full_n, half_n, aeaf_n}, {27'b0, flags_for(model.size())});
  endtask

  function automatic logic [15:0] pattern(input int k);
    return 16'hA5C3 ^ 16'(k * 16'h1357) ^ 16'(k << 9);
  endfunction

  task automatic push_word(input logic [15:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic shift_word(input logic dir, input logic also_write, input logic [15:0] wd);
    logic [15:0] w;
    w = model[0];
    msb_first = dir;
    for (int b = 0; b < 16; b++) begin
      sclk_en = 1'b1;
      if (also_write && b == 15) begin
        wr_valid = 1'b1;
        wr_data  = wd;
      end
      @(posedge clk); #1;
      sclk_en  = 1'b0;
      wr_valid = 1'b0;
      // R3 R4: one bit per strobe, order chosen by msb_first
      check(dir ? "R4 msb-first bit" : "R3 R4 lsb-first bit", {31'b0, ser_bit},
            {31'b0, dir ? w[15 - b] : w[b]});
      if (b == 15) begin
        void'(model.pop_front());
        if (also_write) model.push_back(wd);
        check_flags("R5 R11 flags after final bit");
      end else begin
        check_flags("R5 flags mid-word");
      end
    end
    last_bit = dir ? w[0] : w[15];
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<200000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    check("R6 reset flags", {28'b0, empty_n, full_n, half_n, aeaf_n}, {28'b0, 4'b0110});
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_flags("R6 R9 flags after reset release");

    // Strobe at empty: ignored (R9)
    sclk_en = 1'b1;
    @(posedge clk); #1;
    sclk_en = 1'b0;
    check("R9 strobe at empty", {31'b0, ser_bit}, 32'd0);
    check_flags("R9 still empty");

    // Fill sweep R1 R7 R8 R10
    for (int k = 0; k < DEPTH; k++) begin
      push_word(pattern(k));
      model.push_back(pattern(k));
      check_flags("R1 R7 R8 R10 fill step");
    end

    // Blocked write at full (R2)
    push_word(16'hDEAD);
    check_flags("R2 write at full ignored");

    // Drain sweep with alternating order (R3 R4 R5 R7 R8)
    for (int k = 0; k < DEPTH; k++) begin
      shift_word(k[0], 1'b0, 16'h0);
    end
    check_flags("R9 empty after drain");

    // Strobes at empty keep last bit (R9)
    for (int s = 0; s < 3; s++) begin
      sclk_en = 1'b1;
      @(posedge clk); #1;
      sclk_en = 1'b0;
      check("R9 last bit held", {31'b0, ser_bit}, {31'b0, last_bit});
    end

    // Coincident write and completing read at the 1/8 boundary (R11)
    push_word(16'h1234);
    model.push_back(16'h1234);
    push_word(16'hFEDC);
    model.push_back(16'hFEDC);
    check_flags("R8 at lower band edge");
    shift_word(1'b1, 1'b1, 16'h0F0F);
    check("R11 occupancy kept, band flag high", {31'b0, aeaf_n}, 32'd1);
    while (model.size() > 0) shift_word(1'b0, 1'b0, 16'h0);
    check_flags("R11 drained");

    // Refill to full and probe the word sequence for the dropped word (R2)
    for (int k = 0; k < DEPTH; k++) begin
      push_word(pattern(k + 40));
      model.push_back(pattern(k + 40));
    end
    push_word(16'hBEEF);
    check("R10 full_n low", {31'b0, full_n}, 32'd0);
    while (model.size() > 0) shift_word(1'b1, 1'b0, 16'h0);
    check_flags("R2 nothing extra stored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule